// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Storage and Floating Parallel Outputs

This block turns a serial bit stream into a parallel word. Each rising edge of the clock pushes the serial input bit into the low end of a chain of stages, and the rest of the chain moves up by one place. The last stage is available on two serial taps for cascading. The first tap changes on the rising edge. The second tap presents the same bit half a clock later, on the falling edge, which helps when the next device sees slow clock edges.

A storage register sits between the chain and the parallel pins. The storage register is a level-sensitive latch. While the strobe is high it passes the chain contents straight through, so every rising edge with the strobe high changes the pins at once. While the strobe is low it holds the last value it passed. An output-enable input either drives the stored word onto the pins or leaves all of them at high impedance. It has no effect on any register inside the block.

Top module: `sipo_shift_store`

## Requirements
- R1: While `rst` is high at a rising clock edge, every stage, the storage register and `ser_q_rise` become 0. `ser_q_fall` becomes 0 at a falling edge with `rst` high.
- R2: At each rising edge with `rst` low, stage 0 takes `ser_in` and stage n+1 takes the old value of stage n.
- R3: `ser_q_rise` shows the last stage. Right after a rising edge it equals what the second-to-last stage held before that edge.
- R4: `ser_q_fall` takes the last-stage value at the falling edge that follows a rising edge. Between the rising edge and that falling edge it keeps its old value.
- R5: While `strobe` is high the storage register follows the chain. While `strobe` is low it holds its value through any number of shifts.
- R6: A rising edge that occurs while `strobe` is high changes `par_q` in that same clock cycle.
- R7: With `out_en` high, bit n of `par_q` drives storage bit n, and bit 0 is the most recently entered serial bit. With `out_en` low, every bit of `par_q` is high impedance.
- R8: `out_en` changes no register. Shifting goes on and `ser_q_rise` keeps updating while the outputs float. When `out_en` returns high, the pins show the word the chain and latch would hold anyway.
- R9: Two instances chained through `ser_q_rise`, and two chained through `ser_q_fall`, hold the same 16-bit word after 16 clocks and a strobe pulse. The first bit entered appears at bit 7 of the downstream device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. Shifts on the rising edge; the delayed tap updates on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | Storage latch enable; transparent while high |
| out_en | input | 1 | Parallel output enable; high drives, low floats |
| par_q | output | STAGES | Parallel word from the storage register, or high impedance |
| ser_q_rise | output | 1 | Last stage, updated on the rising edge |
| ser_q_fall | output | 1 | Last stage, retimed to the falling edge |

## Verification
The chain and `ser_q_rise` settle one register after a rising edge. The bench drives inputs and samples them 2 ns after that edge, well before the falling edge. `ser_q_fall` is checked twice in each cycle: at the post-rise sample, where it must still hold the old bit, and again 1 ns after the falling edge, where it must show the new bit. The path from `strobe` and `out_en` to `par_q` has no clock, so those results are sampled 1 ns after the input changes. The effect of a shift through a transparent latch is read in the same post-rise sample as the chain.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // default depth of the shift chain and of the parallel word
  localparam int unsigned SIPO_DEF_STAGES = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [STAGES-1:0] stage_q
);
  logic [STAGES-1:0] stg;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= 1'b0;
          else     stg[0] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) stg[gi] <= 1'b0;
          else     stg[gi] <= stg[gi-1];
        end
      end
    end
  endgenerate

  assign stage_q = stg;

  // R2: serial input enters stage 0
  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stg[0] == $past(din));
  // R2: every stage moves up by one
  a_r2_shift_move: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stg[STAGES-1:1] == $past(stg[STAGES-2:0]));
endmodule

// File: rtl/sipo_fall_tap.sv
module sipo_fall_tap (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/sipo_store_latch.sv
module sipo_store_latch #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  always_latch begin
    if (rst)         q <= '0;
    else if (strobe) q <= d;
  end

  // R5: transparent while strobe is high
  a_r5_transparent: assert property (@(posedge clk) disable iff (rst)
    strobe |-> q == d);
  // R5: holds while strobe stays low
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !$past(strobe)) |-> $stable(q));
endmodule

// File: rtl/sipo_shift_store.sv
module sipo_shift_store
  import sipo_pkg::*;
#(
  parameter int unsigned STAGES = SIPO_DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              out_en,
  output wire  [STAGES-1:0] par_q,
  output logic              ser_q_rise,
  output logic              ser_q_fall
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] store_q;

  sipo_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .din     (ser_in),
    .stage_q (chain_q)
  );

  sipo_fall_tap u_fall (
    .clk (clk),
    .rst (rst),
    .d   (chain_q[LAST]),
    .q   (ser_q_fall)
  );

  sipo_store_latch #(.STAGES(STAGES)) u_store (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .d      (chain_q),
    .q      (store_q)
  );

  assign ser_q_rise = chain_q[LAST];
  assign par_q      = out_en ? store_q : {STAGES{1'bz}};

  // R3: rising tap shows the old second-to-last stage after the edge
  a_r3_rise_tap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ser_q_rise == $past(chain_q[LAST-1]));
  // R4: falling tap has caught up with the rising tap by the next rising edge
  a_r4_fall_tap: assert property (@(posedge clk) disable iff (rst)
    ser_q_fall == ser_q_rise);
endmodule

// File: tb/sipo_shift_store_tb.sv
`timescale 1ns/1ps
module sipo_shift_store_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0, stb = 1'b0, oe = 1'b1;
  logic cdin = 1'b0, cstb = 1'b0;

  wire [W-1:0] par;
  logic q_rise, q_fall;
  wire [W-1:0] pa1, pb0, pb1;
  logic ra0, fa0, ra1, fa1, rb0, fb0, rb1, fb1;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0]  model;
  logic [15:0]   model16;

  always #(CLK_PERIOD/2) clk = ~clk;

  sipo_shift_store #(.STAGES(W)) u_dut (
    .clk(clk), .rst(rst), .ser_in(din), .strobe(stb), .out_en(oe),
    .par_q(par), .ser_q_rise(q_rise), .ser_q_fall(q_fall));

  // rising-tap cascade: u_ra0 feeds u_ra1
  wire [W-1:0] pa0;
  sipo_shift_store #(.STAGES(W)) u_ra0 (
    .clk(clk), .rst(rst), .ser_in(cdin), .strobe(cstb), .out_en(1'b1),
    .par_q(pa0), .ser_q_rise(ra0), .ser_q_fall(fa0));
  sipo_shift_store #(.STAGES(W)) u_ra1 (
    .clk(clk), .rst(rst), .ser_in(ra0), .strobe(cstb), .out_en(1'b1),
    .par_q(pa1), .ser_q_rise(ra1), .ser_q_fall(fa1));
  // falling-tap cascade: u_fb0 feeds u_fb1
  sipo_shift_store #(.STAGES(W)) u_fb0 (
    .clk(clk), .rst(rst), .ser_in(cdin), .strobe(cstb), .out_en(1'b1),
    .par_q(pb0), .ser_q_rise(rb0), .ser_q_fall(fb0));
  sipo_shift_store #(.STAGES(W)) u_fb1 (
    .clk(clk), .rst(rst), .ser_in(fb0), .strobe(cstb), .out_en(1'b1),
    .par_q(pb1), .ser_q_rise(rb1), .ser_q_fall(fb1));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive din, then wait to 2 ns after the next rising edge
  task automatic shift_bit(input logic b);
    din = b;
    cdin = b;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1; stb = 1'b0; oe = 1'b1; din = 1'b1; cdin = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0; din = 1'b0; cdin = 1'b0;
    model = '0; model16 = '0;
    check("R1 rise tap", {15'd0, q_rise}, 16'd0);
    check("R1 fall tap", {15'd0, q_fall}, 16'd0);
    check("R1 storage", {8'd0, par}, 16'd0);
    stb = 1'b1; #1;
    check("R1 chain via open latch", {8'd0, par}, 16'd0);
  endtask

  task automatic t_shift();
    logic [W-1:0] pat = 8'b1011_0010;
    logic prev;
    for (int i = W-1; i >= 0; i--) begin
      prev = model[W-1];
      shift_bit(pat[i]);
      model = {model[W-2:0], pat[i]};
      check("R2/R6 parallel follows shift", {8'd0, par}, {8'd0, model});
      check("R3 rise tap", {15'd0, q_rise}, {15'd0, model[W-1]});
      check("R4 fall tap holds before falling edge", {15'd0, q_fall}, {15'd0, prev});
      #4;
      check("R4 fall tap after falling edge", {15'd0, q_fall}, {15'd0, model[W-1]});
    end
    check("R7 bit0 newest", {15'd0, par[0]}, {15'd0, pat[0]});
  endtask

  task automatic t_hold();
    logic [W-1:0] held;
    held = model;
    stb = 1'b0;
    for (int i = 0; i < 3; i++) begin
      shift_bit(i[0] ? 1'b0 : 1'b1);
      model = {model[W-2:0], (i[0] ? 1'b0 : 1'b1)};
      check("R5 storage holds with strobe low", {8'd0, par}, {8'd0, held});
    end
    stb = 1'b1; #1;
    check("R5 strobe reopens latch", {8'd0, par}, {8'd0, model});
  endtask

  task automatic t_oe();
    oe = 1'b0; #1;
    check("R7 outputs float", {8'd0, par}, {8'd0, {W{1'bz}}});
    for (int i = 0; i < 4; i++) begin
      shift_bit(i[1]);
      model = {model[W-2:0], i[1]};
      check("R8 rise tap shifts while floating", {15'd0, q_rise}, {15'd0, model[W-1]});
      check("R7 still floating", {8'd0, par}, {8'd0, {W{1'bz}}});
    end
    oe = 1'b1; #1;
    check("R8 registers unaffected by out_en", {8'd0, par}, {8'd0, model});
  endtask

  task automatic t_cascade();
    logic [15:0] pat = 16'hC3A5;
    cstb = 1'b0;
    stb = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      shift_bit(pat[i]);
      model16 = {model16[14:0], pat[i]};
    end
    cstb = 1'b1; #1;
    check("R9 rise chain downstream", {8'd0, pa1}, {8'd0, model16[15:8]});
    check("R9 rise chain upstream", {8'd0, pa0}, {8'd0, model16[7:0]});
    check("R9 fall chain downstream", {8'd0, pb1}, {8'd0, model16[15:8]});
    check("R9 fall chain upstream", {8'd0, pb0}, {8'd0, model16[7:0]});
    check("R9 first bit at downstream bit 7", {15'd0, pb1[7]}, {15'd0, pat[15]});
    cstb = 1'b0;
  endtask

  initial begin
    t_reset();
    t_shift();
    t_hold();
    t_oe();
    t_cascade();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule